// File: doc/BRIEF.md
# Periodic System Tick Down-Counter

This block is a memory-mapped down-counter that produces a steady stream of timer interrupts, such as an operating-system scheduler tick. Software sets a period through the reload register and enables the counter. The counter then decrements on every core clock, or only on cycles where an external reference-tick enable is high; a control bit picks the source.

Each time the count runs out, the block sets a sticky expiry flag. It pulses an interrupt request for one cycle if that is enabled, and then starts the next period. A reload of zero gives a one-shot: the counter turns itself off after the first expiry. Reading the status register clears the flag. Writing the current-value register restarts the period.

Clearing the enable pauses the counter without losing the remaining count. Setting it again continues from the paused count. A fixed calibration word is also readable. The register port is synchronous. Read data is valid in the cycle of the access, and any side effect takes place at the end of that cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset, the status, reload and current-value registers read 0 and irq is 0.
- R2: A write to status (offset 0x10) changes only enable (bit 0), interrupt enable (bit 1) and clock source (bit 2). Bit 16 is the expiry flag, and a write never sets or clears it.
- R3: A read of status returns the flag in bit 16, and the flag is clear after that access unless an expiry happens in the same cycle.
- R4: One period is reload+1 counting ticks. Expiry sets the flag, and with bit 1 set raises irq for exactly one cycle.
- R5: When the reload value is 0 at an expiry, the enable bit clears and counting stops.
- R6: A write of any value to the current-value register (offset 0x18) loads the count from the reload register and clears the flag.
- R7: The current-value register reads 0 whenever enable is 0.
- R8: Clearing enable freezes the count. Setting it again resumes from the frozen count when that count is nonzero, and otherwise loads the reload value.
- R9: A status write that flips the clock-source bit but leaves enable unchanged reloads the count.
- R10: The calibration register (offset 0x1C) always reads 10000 decimal, and writes to it have no effect.
- R11: With clock source 1 the count drops on every clock. With clock source 0 it drops only in cycles where ref_tick is 1.
- R12: irq stays 0 while the interrupt-enable bit is 0, even though expiries continue.
- R13: The reload register (offset 0x14) keeps only the low 24 bits written, and its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access; 0 otherwise |
| ref_tick | input | 1 | External reference tick enable |
| irq | output | 1 | One-cycle interrupt request at expiry |

## Verification
A wrong count value shows on the current-value register in the same cycle. It also shows in the timing of the next irq pulse, which then arrives early or late by the size of the error. A flag that is stuck or cleared early shows on the first status read. A wrong enable state after a zero-reload expiry shows as soon as status or current value is read, or as an irq that never comes. The bench measures each period in counting ticks to the exact cycle, so an error of even one step in the count, or in the suppression of counting on writes, is caught.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   localparam int unsigned REG_W      = 32;
   localparam int unsigned OFS_CTRL   = 'h10;
   localparam int unsigned OFS_RELOAD = 'h14;
   localparam int unsigned OFS_CUR    = 'h18;
   localparam int unsigned OFS_CAL    = 'h1C;
   localparam int unsigned FLAG_BIT   = 16;

   // bit 2 = clock source, bit 1 = interrupt enable, bit 0 = enable
   typedef struct packed {
      logic src;
      logic tint;
      logic en;
   } ctl_t;

   function automatic logic [REG_W-1:0] status_word(ctl_t c, logic flag);
      logic [REG_W-1:0] w;
      w           = '0;
      w[2:0]      = c;
      w[FLAG_BIT] = flag;
      return w;
   endfunction

endpackage

// File: rtl/tick_ref_sel.sv
module tick_ref_sel #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   output logic ref_lvl
);
   if (STAGES == 0) begin : g_direct
      assign ref_lvl = ref_tick;
   end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2+1-1 -: 0+STAGES-1 > 0 ? STAGES-1 : 1], ref_tick};
      end
      assign ref_lvl = sh_q[STAGES-1];
   end
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             count_zero
);
   assign count_zero = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= reload;
      else if (step) count <= count_zero ? reload : count - 1'b1;
   end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
   import tick_timer_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              ref_lvl,
   input  logic              count_zero,
   output ctl_t              ctl,
   output logic              flag,
   output logic [CNT_W-1:0]  reload,
   output logic              load,
   output logic              step,
   output logic              expire,
   output logic              irq
);
   logic wr_ctl, wr_rld, wr_cur, rd_ctl;
   ctl_t wctl;
   logic en_rise, src_flip;

   assign wr_ctl = bus_en &  bus_we & (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_rld = bus_en &  bus_we & (bus_addr == ADDR_W'(OFS_RELOAD));
   assign wr_cur = bus_en &  bus_we & (bus_addr == ADDR_W'(OFS_CUR));
   assign rd_ctl = bus_en & ~bus_we & (bus_addr == ADDR_W'(OFS_CTRL));
   assign wctl   = ctl_t'(bus_wdata[2:0]);

   assign en_rise  = wr_ctl & wctl.en & ~ctl.en;
   assign src_flip = wr_ctl & (wctl.en == ctl.en) & (wctl.src != ctl.src);

   // a write that touches the count owns that cycle; no tick is taken
   assign load   = wr_cur | (en_rise & count_zero) | src_flip;
   assign step   = ctl.en & (ctl.src | ref_lvl) & ~wr_ctl & ~wr_cur;
   assign expire = step & count_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl    <= '0;
         flag   <= 1'b0;
         reload <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= expire & ctl.tint;
         if (wr_ctl)                         ctl    <= wctl;
         else if (expire && reload == '0)    ctl.en <= 1'b0;
         if (expire)                         flag   <= 1'b1;
         else if (rd_ctl || wr_cur)          flag   <= 1'b0;
         if (wr_rld)                         reload <= bus_wdata[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int CNT_W           = 24,
   parameter int ADDR_W          = 8,
   parameter int CAL_VALUE       = 10000,
   parameter int REF_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ref_tick,
   output logic              irq
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("tick_timer: CNT_W must lie in 2..32");
   end
   if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
      $error("tick_timer: ADDR_W must lie in 5..16");
   end
   if (CAL_VALUE < 0) begin : g_bad_cal
      $error("tick_timer: CAL_VALUE must be non-negative");
   end
   if (REF_SYNC_STAGES < 0 || REF_SYNC_STAGES > 3) begin : g_bad_sync
      $error("tick_timer: REF_SYNC_STAGES must lie in 0..3");
   end

   ctl_t             ctl_q;
   logic             flag_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count_q;
   logic             count_zero;
   logic             load_w, step_w, expire_w, ref_lvl;

   tick_ref_sel #(.STAGES(REF_SYNC_STAGES)) u_ref (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ref_lvl(ref_lvl));

   tick_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ref_lvl(ref_lvl),
      .count_zero(count_zero), .ctl(ctl_q), .flag(flag_q), .reload(reload_q),
      .load(load_w), .step(step_w), .expire(expire_w), .irq(irq));

   tick_timer_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load_w), .step(step_w),
      .reload(reload_q), .count(count_q), .count_zero(count_zero));

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         case (bus_addr)
            ADDR_W'(OFS_CTRL):   bus_rdata = status_word(ctl_q, flag_q);
            ADDR_W'(OFS_RELOAD): bus_rdata = REG_W'(reload_q);
            ADDR_W'(OFS_CUR):    bus_rdata = ctl_q.en ? REG_W'(count_q) : '0;
            ADDR_W'(OFS_CAL):    bus_rdata = REG_W'(CAL_VALUE);
            default:             bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
   import tick_timer_pkg::*;
#(
   parameter int CNT_W     = 24,
   parameter int ADDR_W    = 8,
   parameter int CAL_VALUE = 10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              irq,
   input logic              en,
   input logic              tint,
   input logic              src,
   input logic              flag,
   input logic [CNT_W-1:0]  reload,
   input logic [CNT_W-1:0]  count,
   input logic              load,
   input logic              expire,
   input logic              ref_lvl
);
   logic wr_ctl, wr_cur, rd_ctl, rd_cal;
   assign wr_ctl = bus_en &  bus_we & (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_cur = bus_en &  bus_we & (bus_addr == ADDR_W'(OFS_CUR));
   assign rd_ctl = bus_en & ~bus_we & (bus_addr == ADDR_W'(OFS_CTRL));
   assign rd_cal = bus_en & ~bus_we & (bus_addr == ADDR_W'(OFS_CAL));

   p_ctl_write_keeps_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl |=> flag == $past(flag));

   p_read_clears_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctl && !expire) |=> !flag);

   p_irq_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_with_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   p_zero_reload_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload == '0) |=> !en);

   p_cur_write_reloads_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cur |=> (count == $past(reload)) && !flag);

   p_cur_reads_zero_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == ADDR_W'(OFS_CUR) && !en) |-> bus_rdata == '0);

   p_frozen_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(count));

   p_cal_constant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cal |-> bus_rdata == 32'(CAL_VALUE));

   p_ref_gates_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !src && !ref_lvl && !load) |=> $stable(count));

   p_no_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tint));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CAL_VALUE(CAL_VALUE)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq(irq), .en(ctl_q.en), .tint(ctl_q.tint), .src(ctl_q.src),
   .flag(flag_q), .reload(reload_q), .count(count_q), .load(load_w),
   .expire(expire_w), .ref_lvl(ref_lvl));

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
   localparam int ADDR_W = 8;
   localparam logic [7:0] A_CTL = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;
   localparam logic [31:0] FLAG = 32'h0001_0000;

   // [31:8] reload, [7:4] ref divider, [0] clock source
   localparam int NV = 6;
   localparam logic [31:0] VEC [NV] = '{32'h0000_0311, 32'h0000_0111, 32'h0000_0720,
                                        32'h0000_0530, 32'h0000_0A11, 32'h0000_0210};

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_en = 1'b0, bus_we = 1'b0, ref_tick = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, rv;
   logic irq;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_timer u0 (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_tick(ref_tick), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // all bus tasks start and end just after a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #600000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      rd(A_CTL, rv); chk("R1 status", rv, 32'h0);
      rd(A_RLD, rv); chk("R1 reload", rv, 32'h0);
      rd(A_CUR, rv); chk("R1 current", rv, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd(A_CAL, rv); chk("R10 calibration", rv, 32'd10000);
      wr(A_CAL, 32'h5);
      rd(A_CAL, rv); chk("R10 write ignored", rv, 32'd10000);
      // R2 only low three bits written, flag untouched
      wr(A_CTL, 32'hFFFF_FFFA);
      rd(A_CTL, rv); chk("R2 low bits", rv, 32'h2);
      wr(A_CTL, FLAG);
      rd(A_CTL, rv); chk("R2 flag not writable", rv, 32'h0);
      // R13 reload width
      wr(A_RLD, 32'hFF12_3456);
      rd(A_RLD, rv); chk("R13 reload width", rv, 32'h0012_3456);

      // R4 / R11 period table
      for (int i = 0; i < NV; i++) begin
         automatic logic [23:0] rl  = VEC[i][31:8];
         automatic int          dv  = int'(VEC[i][7:4]);
         automatic logic        src = VEC[i][0];
         automatic int          ticks = 0;
         automatic bit          seen = 1'b0;
         wr(A_CTL, 32'h0);
         wr(A_RLD, {8'h0, rl});
         wr(A_CUR, 32'h0);
         wr(A_CTL, {29'b0, src, 2'b11});
         for (int k = 0; k < 2000 && !seen; k++) begin
            ref_tick = ((k % dv) == dv - 1);
            @(posedge clk);
            if (src || ref_tick) ticks++;
            @(negedge clk);
            if (irq) seen = 1'b1;
         end
         ref_tick = 1'b0;
         chk(src ? "R4 period core clock" : "R11 period ref tick", ticks, 32'(rl) + 32'd1);
         wr(A_CTL, 32'h0);
         chk("R4 irq one cycle", {31'b0, irq}, 32'h0);
         rd(A_CTL, rv); chk("R3 flag read", rv, FLAG);
         rd(A_CTL, rv); chk("R3 flag cleared", rv, 32'h0);
      end

      // R7 / R8 / R9 / R11 count behaviour
      wr(A_RLD, 32'd100);
      wr(A_CUR, 32'h0);
      rd(A_CUR, rv); chk("R7 zero while off", rv, 32'h0);
      wr(A_CTL, 32'h5);
      rd(A_CUR, rv); chk("R8 start", rv, 32'd100);
      rd(A_CUR, rv); chk("R11 every clock", rv, 32'd99);
      wr(A_CTL, 32'h4);
      idle(5);
      wr(A_CTL, 32'h5);
      rd(A_CUR, rv); chk("R8 resume frozen", rv, 32'd98);
      wr(A_CTL, 32'h1);
      rd(A_CUR, rv); chk("R9 source change reload", rv, 32'd100);
      idle(3);
      rd(A_CUR, rv); chk("R11 no ref no count", rv, 32'd100);
      ref_tick = 1'b1; @(posedge clk); @(negedge clk); ref_tick = 1'b0;
      rd(A_CUR, rv); chk("R11 one ref tick", rv, 32'd99);

      // R12 / R6
      wr(A_CTL, 32'h0);
      wr(A_RLD, 32'd2);
      wr(A_CUR, 32'h0);
      wr(A_CTL, 32'h5);
      begin
         automatic bit any = 1'b0;
         for (int k = 0; k < 10; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq) any = 1'b1;
         end
         chk("R12 no irq when masked", {31'b0, any}, 32'h0);
      end
      wr(A_CUR, 32'h1234);
      rd(A_CTL, rv); chk("R6 flag cleared by write", rv, 32'h5);
      rd(A_CUR, rv); chk("R6 reloaded count", rv, 32'd1);
      wr(A_CTL, 32'h0);

      // R5 zero reload one-shot
      wr(A_RLD, 32'h0);
      wr(A_CUR, 32'h0);
      wr(A_CTL, 32'h7);
      @(posedge clk); @(negedge clk);
      chk("R5 irq at expiry", {31'b0, irq}, 32'h1);
      rd(A_CTL, rv); chk("R5 enable cleared", rv, FLAG | 32'h6);
      chk("R4 irq dropped", {31'b0, irq}, 32'h0);
      rd(A_CTL, rv); chk("R3 flag gone", rv, 32'h6);
      rd(A_CUR, rv); chk("R7 stopped reads zero", rv, 32'h0);
      idle(4);
      chk("R5 no further irq", {31'b0, irq}, 32'h0);

      finish_run();
   end
endmodule